// File: doc/BRIEF.md
# Byte-Wise CRC-16 Lookup Table Builder

This block fills a 256-entry by 16-bit table with the byte-at-a-time lookup values for a 16-bit CRC polynomial. A single start pulse captures the polynomial and a bit-order select. The engine then writes all 256 entries through a write port of address, data and enable. The select chooses most-significant-bit-first (normal) order or least-significant-bit-first (reflected) order. In reflected order the caller supplies the bit-reversed polynomial.

The engine keeps its own copy of the table in a synchronous memory and reads entries back from it. It uses the linearity of the table: the entry at `a XOR b` equals the entry at `a` XOR the entry at `b`. A working register takes one polynomial shift step for each power-of-two index, which gives eight shift steps in all. Every other entry is that register XOR an entry written earlier. Each such entry costs one read clock and one write clock. A host observes the write port to mirror the table into its own storage.

Top module: `crc_tbl_builder`

## Requirements
- R1: One clock after an accepted start, the first write goes to address 0 with data 0.
- R2: With `lsb_first`=0, the entry at address b equals the value found by loading b into bits 15..8 of a zeroed 16-bit register and then applying eight steps. Each step shifts the register left by one and XORs in `poly` when the bit shifted out was 1.
- R3: With `lsb_first`=1, the entry at address b equals the value found by loading b into bits 7..0 of a zeroed register and then applying eight steps. Each step shifts the register right by one and XORs in `poly` when the bit shifted out was 1.
- R4: A run makes exactly 256 writes and never writes the same address twice.
- R5: With `lsb_first`=0, the write addresses run 0, 1, 2, … 255 in that order. With `lsb_first`=1, address 0 comes first. Then, for i = 128, 64, … 1 in turn, the run writes addresses i, 3i, 5i, … in ascending order up to 255.
- R6: `busy` goes high on the clock after an accepted start and stays high for exactly 519 clocks. These are one clock for entry 0, one clock for each of the 8 shift steps, and two clocks for each of the other 255 entries.
- R7: `done` is high for exactly one clock: the first clock in which `busy` is low after a run.
- R8: A `start` while `busy` is high is ignored. Changes to `lsb_first` or `poly` during a run do not alter the run's writes, its order or its length.
- R9: Whenever `rst_n` is low, `busy`, `done` and `wr_en` are low, and this includes an assertion of reset in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| lsb_first | input | 1 | 0: normal bit order, 1: reflected bit order |
| poly | input | 16 | Polynomial (bit-reversed when lsb_first is 1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse after the last write |
| wr_en | output | 1 | Table write strobe |
| wr_addr | output | 8 | Table write address |
| wr_data | output | 16 | Table write data |

## Verification
The builder is run with the common normal and reflected forms of two well-known polynomials, and each run is checked against known table entries. This separates errors in the shift direction from errors in the polynomial tap. Runs with all-zero and all-ones polynomials, and with random polynomials in both orders, test whether the XOR fill uses the correct earlier entry. A wrong source index shows up as a data mismatch even when the power-of-two entries are right. Runs that change `start`, `lsb_first` and `poly` in the middle of a run, and a reset in the middle of a run, separate a properly latched configuration from one that follows its inputs live.

// File: rtl/crc_tbl_pkg.sv
package crc_tbl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ZERO = 3'd1,
    ST_STEP = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4
  } crc_tbl_state_e;
endpackage

// File: rtl/crc_tbl_rst_sync.sv
module crc_tbl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/crc_tbl_ram.sv
module crc_tbl_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/crc_tbl_shift.sv
module crc_tbl_shift #(
  parameter int W = 16
) (
  input  logic         lsb,
  input  logic [W-1:0] poly,
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic [W-1:0] shl, shr;

  assign shl = {cur[W-2:0], 1'b0} ^ (cur[W-1] ? poly : '0);
  assign shr = {1'b0, cur[W-1:1]} ^ (cur[0]   ? poly : '0);
  assign nxt = lsb ? shr : shl;
endmodule

// File: rtl/crc_tbl_ctrl.sv
module crc_tbl_ctrl
  import crc_tbl_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             lsb_first,
  input  logic [CRC_W-1:0] poly,
  input  logic [CRC_W-1:0] work_nxt,
  output logic [CRC_W-1:0] work_q,
  output logic             lsb_q,
  output logic [CRC_W-1:0] poly_q,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  input  logic [CRC_W-1:0] rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [CRC_W-1:0] wr_data,
  output logic             busy,
  output logic             done
);
  localparam int               ENTRIES  = 1 << IDX_W;
  localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(ENTRIES / 2);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);
  localparam logic [IDX_W:0]   END_J    = (IDX_W+1)'(ENTRIES);
  localparam logic [CRC_W-1:0] MSB_SEED = CRC_W'(1) << (CRC_W - 1);
  localparam logic [CRC_W-1:0] LSB_SEED = CRC_W'(1);

  crc_tbl_state_e   st_q, st_d;
  logic [IDX_W-1:0] i_q, i_d;
  logic [IDX_W:0]   j_q, j_d, j_nx;
  logic [CRC_W-1:0] work_d;
  logic             done_q, done_d;
  logic             cfg_ld, work_en, i_en, j_en;
  logic             last_grp, last_run;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    i_d      = i_q;
    j_d      = j_q;
    work_d   = work_q;
    done_d   = 1'b0;
    cfg_ld   = 1'b0;
    work_en  = 1'b0;
    i_en     = 1'b0;
    j_en     = 1'b0;
    rd_en    = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    j_nx     = '0;
    last_grp = 1'b0;
    last_run = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          cfg_ld  = 1'b1;
          work_en = 1'b1;
          work_d  = lsb_first ? LSB_SEED : MSB_SEED;
          i_en    = 1'b1;
          i_d     = lsb_first ? HALF_IDX : ONE_IDX;
          st_d    = ST_ZERO;
        end
      end
      ST_ZERO: begin
        wr_en = 1'b1;
        st_d  = ST_STEP;
      end
      ST_STEP: begin
        work_en = 1'b1;
        work_d  = work_nxt;
        j_en    = 1'b1;
        j_d     = '0;
        st_d    = ST_RD;
      end
      ST_RD: begin
        rd_en = 1'b1;
        st_d  = ST_WR;
      end
      ST_WR: begin
        wr_en   = 1'b1;
        wr_addr = i_q ^ j_q[IDX_W-1:0];
        wr_data = work_q ^ rd_data;
        if (!lsb_q) begin
          j_nx     = j_q + (IDX_W+1)'(1);
          last_grp = (j_nx == {1'b0, i_q});
          last_run = (i_q == HALF_IDX);
        end else begin
          j_nx     = j_q + {i_q, 1'b0};
          last_grp = (j_nx >= END_J);
          last_run = (i_q == ONE_IDX);
        end
        if (last_grp) begin
          if (last_run) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            i_en = 1'b1;
            i_d  = lsb_q ? (i_q >> 1) : (i_q << 1);
            st_d = ST_STEP;
          end
        end else begin
          j_en = 1'b1;
          j_d  = j_nx;
          st_d = ST_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (cfg_ld) begin
      lsb_q  <= lsb_first;
      poly_q <= poly;
    end
    if (work_en) work_q <= work_d;
    if (i_en)    i_q    <= i_d;
    if (j_en)    j_q    <= j_d;
  end

  assign rd_addr = j_q[IDX_W-1:0];
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/crc_tbl_builder.sv
module crc_tbl_builder #(
  parameter int CRC_W = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             lsb_first,
  input  logic [CRC_W-1:0] poly,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [CRC_W-1:0] wr_data
);
  logic             rst_sync_n;
  logic [CRC_W-1:0] work_q, work_nxt, poly_q, rd_data;
  logic             lsb_q, rd_en, busy_i, done_i;
  logic [IDX_W-1:0] rd_addr;

  crc_tbl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crc_tbl_ctrl #(.CRC_W(CRC_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .lsb_first (lsb_first),
    .poly      (poly),
    .work_nxt  (work_nxt),
    .work_q    (work_q),
    .lsb_q     (lsb_q),
    .poly_q    (poly_q),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy_i),
    .done      (done_i)
  );

  crc_tbl_shift #(.W(CRC_W)) u_shift (
    .lsb  (lsb_q),
    .poly (poly_q),
    .cur  (work_q),
    .nxt  (work_nxt)
  );

  crc_tbl_ram #(.AW(IDX_W), .DW(CRC_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign busy = busy_i;
  assign done = done_i;
endmodule

// File: rtl/crc_tbl_builder_chk.sv
module crc_tbl_builder_chk #(
  parameter int CRC_W = 16,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             lsb_first,
  input logic [CRC_W-1:0] poly,
  input logic             busy,
  input logic             done,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_addr,
  input logic [CRC_W-1:0] wr_data
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int RUN_CYC = 1 + IDX_W + 2 * (ENTRIES - 1);

  logic             lsb_c;
  logic [CRC_W-1:0] poly_c;
  int unsigned      wr_cnt, busy_cnt;

  function automatic logic [CRC_W-1:0] bitwise_entry(
    input logic [IDX_W-1:0] idx, input logic lsb, input logic [CRC_W-1:0] p);
    logic [CRC_W-1:0] c;
    c = lsb ? CRC_W'(idx) : (CRC_W'(idx) << (CRC_W - IDX_W));
    for (int k = 0; k < IDX_W; k++) begin
      if (lsb) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
      else     c = c[CRC_W-1] ? ((c << 1) ^ p) : (c << 1);
    end
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_c    <= 1'b0;
      poly_c   <= '0;
      wr_cnt   <= 0;
      busy_cnt <= 0;
    end else if (start && !busy) begin
      lsb_c    <= lsb_first;
      poly_c   <= poly;
      wr_cnt   <= 0;
      busy_cnt <= 0;
    end else begin
      if (wr_en) wr_cnt   <= wr_cnt + 1;
      if (busy)  busy_cnt <= busy_cnt + 1;
    end
  end

  p_first_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (wr_en && wr_addr == '0 && wr_data == '0));

  p_msb_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lsb_c) |-> (wr_data == bitwise_entry(wr_addr, 1'b0, poly_c)));

  p_lsb_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lsb_c) |-> (wr_data == bitwise_entry(wr_addr, 1'b1, poly_c)));

  p_write_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_cnt == ENTRIES));

  p_run_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == RUN_CYC));

  p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
endmodule

bind crc_tbl_builder crc_tbl_builder_chk #(.CRC_W(CRC_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .lsb_first (lsb_first),
  .poly      (poly),
  .busy      (busy),
  .done      (done),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/crc_tbl_builder_tb.sv
`timescale 1ns/1ps
module crc_tbl_builder_tb;
  localparam int CRC_W   = 16;
  localparam int IDX_W   = 8;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int RUN_CYC = 519;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             lsb_first = 1'b0;
  logic [CRC_W-1:0] poly = '0;
  logic             busy, done, wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [CRC_W-1:0] wr_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [CRC_W-1:0] shadow [ENTRIES];
  bit               seen   [ENTRIES];
  int               order  [ENTRIES];
  int               exp_ord[ENTRIES];
  int n_wr, n_dup, busy_cyc, done_cnt, done_bad;
  logic prev_busy = 1'b0;

  crc_tbl_builder #(.CRC_W(CRC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lsb_first(lsb_first), .poly(poly),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // write-port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (n_wr < ENTRIES) order[n_wr] = int'(wr_addr);
        if (seen[wr_addr]) n_dup++;
        seen[wr_addr]   = 1'b1;
        shadow[wr_addr] = wr_data;
        n_wr++;
      end
      if (busy) busy_cyc++;
      if (done) begin
        done_cnt++;
        if (busy || !prev_busy) done_bad++;
      end
      prev_busy = busy;
    end else begin
      prev_busy = 1'b0;
    end
  end

  function automatic logic [CRC_W-1:0] ref_entry(input int b, input bit lsb,
                                                 input logic [CRC_W-1:0] p);
    logic [CRC_W-1:0] c;
    c = lsb ? CRC_W'(b) : (CRC_W'(b) << 8);
    for (int k = 0; k < 8; k++) begin
      if (lsb) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
      else     c = c[15] ? ((c << 1) ^ p) : (c << 1);
    end
    return c;
  endfunction

  task automatic clear_mon();
    for (int a = 0; a < ENTRIES; a++) begin
      seen[a] = 1'b0; order[a] = -1; shadow[a] = '0;
    end
    n_wr = 0; n_dup = 0; busy_cyc = 0; done_cnt = 0; done_bad = 0;
  endtask

  task automatic run(input bit lsb, input logic [CRC_W-1:0] p, input bit disturb);
    int idx, mism, omis, first_bad;
    @(negedge clk);
    clear_mon();
    start = 1'b1; lsb_first = lsb; poly = p;
    @(negedge clk);
    start = 1'b0; lsb_first = 1'($urandom); poly = CRC_W'($urandom);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (disturb && k == 100) begin
        start = 1'b1; lsb_first = ~lsb; poly = ~p;
      end else begin
        start = 1'b0;
      end
      if (done_cnt > 0) break;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);

    // expected order
    if (!lsb) begin
      for (int a = 0; a < ENTRIES; a++) exp_ord[a] = a;
    end else begin
      exp_ord[0] = 0; idx = 1;
      for (int ii = ENTRIES / 2; ii >= 1; ii = ii / 2)
        for (int jj = 0; jj < ENTRIES; jj += 2 * ii) begin
          exp_ord[idx] = ii ^ jj; idx++;
        end
    end
    mism = 0; omis = 0; first_bad = -1;
    for (int a = 0; a < ENTRIES; a++) begin
      if (!seen[a] || shadow[a] !== ref_entry(a, lsb, p)) begin
        mism++;
        if (first_bad < 0) first_bad = a;
      end
      if (order[a] != exp_ord[a]) omis++;
    end
    check(order[0] == 0 && shadow[0] == 16'h0, "R1", "first write addr",
          order[0], 0);
    if (lsb) check(mism == 0, "R3", "reflected entries wrong, count", mism, 0);
    else     check(mism == 0, "R2", "normal entries wrong, count", mism, 0);
    if (first_bad >= 0)
      check(1'b0, lsb ? "R3" : "R2", "first bad entry data",
            int'(shadow[first_bad]), int'(ref_entry(first_bad, lsb, p)));
    check(n_wr == ENTRIES, "R4", "write count", n_wr, ENTRIES);
    check(n_dup == 0, "R4", "duplicate writes", n_dup, 0);
    check(omis == 0, "R5", "order mismatches", omis, 0);
    check(busy_cyc == RUN_CYC, "R6", "busy cycles", busy_cyc, RUN_CYC);
    check(done_cnt == 1 && done_bad == 0, "R7", "done pulses", done_cnt, 1);
    check(!busy && !wr_en, "R7", "idle after done", int'(busy), 0);
    if (disturb)
      check(mism == 0 && busy_cyc == RUN_CYC && omis == 0, "R8",
            "run altered by mid-run start", mism + omis, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_mon();
    repeat (3) @(negedge clk);
    check(!busy && !done && !wr_en, "R9", "outputs in reset",
          {busy, done, wr_en}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !done && !wr_en, "R9", "outputs after reset",
          {busy, done, wr_en}, 0);

    // directed: well-known polynomials in both orders
    run(1'b0, 16'h1021, 1'b0);
    check(shadow[1] == 16'h1021, "R2", "entry 1", shadow[1], 16'h1021);
    check(shadow[255] == 16'h1EF0, "R2", "entry 255", shadow[255], 16'h1EF0);
    run(1'b1, 16'h8408, 1'b0);
    check(shadow[1] == 16'h1189, "R3", "entry 1", shadow[1], 16'h1189);
    check(shadow[128] == 16'h8408, "R3", "entry 128", shadow[128], 16'h8408);
    check(shadow[255] == 16'h0F78, "R3", "entry 255", shadow[255], 16'h0F78);
    run(1'b0, 16'h8005, 1'b0);
    run(1'b1, 16'hA001, 1'b0);
    run(1'b0, 16'h0000, 1'b0);
    run(1'b1, 16'hFFFF, 1'b0);
    run(1'b0, 16'hFFFF, 1'b0);

    // R8: start, mode and polynomial toggled in mid-run
    run(1'b0, 16'h1021, 1'b1);
    run(1'b1, 16'h8408, 1'b1);

    // R9: reset in mid-run
    @(negedge clk);
    start = 1'b1; lsb_first = 1'b0; poly = 16'h1021;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!busy && !done && !wr_en, "R9", "outputs on mid-run reset",
          {busy, done, wr_en}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !wr_en, "R9", "idle after mid-run reset", int'(busy), 0);

    // random polynomials in both orders
    for (int r = 0; r < 6; r++)
      run(1'($urandom), CRC_W'($urandom), (r % 3) == 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule